// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a 24-bit periodic down-counter behind a small register bus. Software programs a reload value, picks one of two tick sources and sets the enable bit. Each tick then steps the counter down; a counter at zero reloads, and the step from one to zero is an expiry. An expiry sets a sticky flag and, when the tick interrupt is enabled, raises a one-cycle interrupt request for an external interrupt controller.

The register bus is a single-cycle strobe interface with no back-pressure. A read or write strobe is held for one cycle with address, privilege and access-size qualifiers. Read data and the error response are valid in that same cycle, and register updates take effect at the closing clock edge. Both tick sources are single-cycle enable inputs that an external clock generator drives. No data stream enters or leaves the block, so no valid/ready handshake is used.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the control bits, the sticky flag, the reload value and the counter read as zero, counting is stopped and `irq_pulse` is low.
- R2: An access gets `bus_err` high in its own cycle, and changes no register, when `bus_priv` is 0, when `bus_full` is 0 (not a 32-bit access), or when the offset is not 0x0, 0x4, 0x8 or 0xC.
- R3: A write to offset 0x0 stores write data bits 2:0 only. A read of offset 0x0 returns run-enable in bit 0, tick-interrupt-enable in bit 1, source select in bit 2, the sticky flag in bit 16 and zero elsewhere.
- R4: A write to offset 0x4 stores write data bits 23:0 as the reload value. A read of 0x4 returns it with bits 31:24 zero.
- R5: While counting, a tick comes from `cpu_clk_en` when the source bit is 1 and from `ref_tick_en` when it is 0. A tick decrements a nonzero counter and loads the reload value into a zero counter. Offset 0x8 reads the counter.
- R6: A tick that moves the counter from 1 to 0 is an expiry. At the edge that ends that cycle the sticky flag sets. If the interrupt-enable bit is 1, `irq_pulse` is high for exactly the following cycle.
- R7: A read of offset 0x0 returns the flag as it was before the read, then clears it. If an expiry happens in the same cycle as the read, the flag ends set.
- R8: Any write to offset 0x8 zeroes the counter and clears the flag. It takes priority over a tick in the same cycle, so that cycle has no expiry. If the reload value is zero at that moment, counting stops.
- R9: An expiry while the reload value is zero stops counting, and the enable bit stays 1.
- R10: A control write that changes enable from 0 to 1 starts counting, and one that clears enable stops it with the counter held. A change of the source bit alone keeps counting. A control write acts on ticks from the next cycle on.
- R11: Offset 0xC reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_clk_en | input | 1 | Processor-rate tick enable (source bit 1) |
| ref_tick_en | input | 1 | Reference tick enable (source bit 0) |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_priv | input | 1 | 1 = privileged master |
| bus_full | input | 1 | 1 = full 32-bit access |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle, zero otherwise |
| bus_err | output | 1 | Error response in the strobe cycle |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
Two pairs of events can fall in the same cycle. An expiry can coincide with a status read, and it can coincide with a write to the counter. The bench holds the counter at one using the reference tick and then raises that tick together with the bus access. For the read, the value returned must show the flag clear and a second read must show it set. For the counter write, the counter and flag must read zero and no interrupt may follow. A cycle-level model in the bench checks the interrupt, the error and the read data on every cycle.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int unsigned OFS_CTRL   = 32'h0;
  localparam int unsigned OFS_RELOAD = 32'h4;
  localparam int unsigned OFS_CUR    = 32'h8;
  localparam int unsigned OFS_CAL    = 32'hC;

  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_IE   = 1;
  localparam int unsigned BIT_SRC  = 2;
  localparam int unsigned BIT_FLAG = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_CUR,
    SEL_CAL
  } reg_sel_e;
endpackage

// File: rtl/tdt_regbus.sv
module tdt_regbus
  import tdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              priv,
  input  logic              full,
  output reg_sel_e          sel,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              err
);
  logic legal;

  always_comb begin
    unique case (addr)
      ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
      ADDR_W'(OFS_RELOAD): sel = SEL_RELOAD;
      ADDR_W'(OFS_CUR):    sel = SEL_CUR;
      ADDR_W'(OFS_CAL):    sel = SEL_CAL;
      default:             sel = SEL_NONE;
    endcase
  end

  assign legal = priv && full && (sel != SEL_NONE);
  assign rd_ok = rd && legal;
  assign wr_ok = wr && legal;
  assign err   = (rd || wr) && !legal;
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (tick) begin
      if (count != '0) count <= count - ONE;
      else             count <= reload;
    end
  end

  assign expire = tick && !clear && (count == ONE);

  // R5: a tick steps a nonzero counter down by one
  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && count != '0) |=> (count == $past(count) - ONE));
  // R5: without tick or clear the counter holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(count));
  // R8: a counter write leaves zero
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_clk_en,
  input  logic              ref_tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_priv,
  input  logic              bus_full,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              irq_pulse
);
  reg_sel_e         sel;
  logic             rd_ok, wr_ok;
  logic             en_q, ie_q, src_q, flag_q, run_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count;
  logic             expire, tick;
  logic             ctrl_wr, rel_wr, cur_wr, ctrl_rd;
  logic             run_nxt;
  logic [DATA_W-1:0] status_word;

  tdt_regbus #(.ADDR_W(ADDR_W)) u_bus (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .priv (bus_priv),
    .full (bus_full),
    .sel  (sel),
    .rd_ok(rd_ok),
    .wr_ok(wr_ok),
    .err  (bus_err)
  );

  assign ctrl_wr = wr_ok && (sel == SEL_CTRL);
  assign rel_wr  = wr_ok && (sel == SEL_RELOAD);
  assign cur_wr  = wr_ok && (sel == SEL_CUR);
  assign ctrl_rd = rd_ok && (sel == SEL_CTRL);

  assign tick = run_q && (src_q ? cpu_clk_en : ref_tick_en);

  tdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .clear (cur_wr),
    .reload(reload_q),
    .count (count),
    .expire(expire)
  );

  always_comb begin
    run_nxt = run_q;
    if (expire && reload_q == '0) run_nxt = 1'b0;
    if (cur_wr && reload_q == '0) run_nxt = 1'b0;
    if (ctrl_wr) begin
      if (!bus_wdata[BIT_EN])   run_nxt = 1'b0;
      else if (!en_q)           run_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      ie_q      <= 1'b0;
      src_q     <= 1'b0;
      flag_q    <= 1'b0;
      run_q     <= 1'b0;
      reload_q  <= '0;
      irq_pulse <= 1'b0;
    end else begin
      run_q     <= run_nxt;
      irq_pulse <= expire && ie_q;
      if (ctrl_wr) begin
        en_q  <= bus_wdata[BIT_EN];
        ie_q  <= bus_wdata[BIT_IE];
        src_q <= bus_wdata[BIT_SRC];
      end
      if (rel_wr) reload_q <= bus_wdata[CNT_W-1:0];
      if (expire)                  flag_q <= 1'b1;
      else if (ctrl_rd || cur_wr)  flag_q <= 1'b0;
    end
  end

  always_comb begin
    status_word           = '0;
    status_word[BIT_EN]   = en_q;
    status_word[BIT_IE]   = ie_q;
    status_word[BIT_SRC]  = src_q;
    status_word[BIT_FLAG] = flag_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      unique case (sel)
        SEL_CTRL:   bus_rdata = status_word;
        SEL_RELOAD: bus_rdata = DATA_W'(reload_q);
        SEL_CUR:    bus_rdata = DATA_W'(count);
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R6: interrupt lasts one cycle
  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R6: interrupt only alongside a set flag
  p_irq_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> flag_q);
  // R2: rejected write leaves reload untouched
  p_badwr_keeps_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_err) |=> $stable(reload_q));
  // R7: status read without expiry clears the flag
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !expire) |=> !flag_q);
  // R9: expiry with zero reload stops counting, enable kept
  p_zero_reload_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload_q == '0 && !ctrl_wr) |=> (!run_q && en_q));
endmodule

// File: tb/tick_down_timer_tb_top.sv
module tick_down_timer_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_en = 1'b0, ref_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0, priv = 1'b1, full = 1'b1;
  logic [31:0] rdata;
  logic        err, irq;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model state
  logic        m_en, m_ie, m_src, m_flag, m_run, m_irq;
  logic [23:0] m_rel, m_cnt;

  always #(PERIOD/2) clk = ~clk;

  tick_down_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_clk_en(cpu_en), .ref_tick_en(ref_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd),
    .bus_priv(priv), .bus_full(full), .bus_rdata(rdata), .bus_err(err),
    .irq_pulse(irq)
  );

  function automatic bit legal_acc();
    return priv && full && (addr == 8'h0 || addr == 8'h4 || addr == 8'h8 || addr == 8'hC);
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (!(rd && legal_acc())) return 32'h0;
    case (addr)
      8'h0: return {15'h0, m_flag, 13'h0, m_src, m_ie, m_en};
      8'h4: return {8'h0, m_rel};
      8'h8: return {8'h0, m_cnt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // model update at each clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_run = 0; m_irq = 0;
      m_rel = '0; m_cnt = '0;
    end else begin
      bit ok, t, cw, xp;
      logic [23:0] c_next;
      ok = legal_acc();
      cw = wr && ok && addr == 8'h8;
      t  = m_run && (m_src ? cpu_en : ref_en);
      xp = t && !cw && m_cnt == 24'd1;
      c_next = m_cnt;
      if (cw) c_next = '0;
      else if (t) c_next = (m_cnt != 0) ? m_cnt - 24'd1 : m_rel;
      if (xp && m_rel == 0) m_run = 0;
      if (cw && m_rel == 0) m_run = 0;
      if (wr && ok && addr == 8'h0) begin
        if (!wdata[0]) m_run = 0;
        else if (!m_en) m_run = 1;
      end
      m_irq = xp && m_ie;
      if (rd && ok && addr == 8'h0) m_flag = 0;
      if (cw) m_flag = 0;
      if (xp) m_flag = 1;
      if (wr && ok && addr == 8'h0) {m_src, m_ie, m_en} = wdata[2:0];
      if (wr && ok && addr == 8'h4) m_rel = wdata[23:0];
      m_cnt = c_next;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cur_req, " irq"}, {31'h0, irq}, {31'h0, m_irq});
      check("R2 err", {31'h0, err}, {31'h0, (rd || wr) && !legal_acc()});
      if (rd) check({cur_req, " rdata"}, rdata, exp_rdata());
    end
  end

  // inputs set at posedge+2 and held for one cycle
  task automatic cyc(input logic r, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic c, input logic f);
    rd = r; wr = w; addr = a; wdata = d; cpu_en = c; ref_en = f;
    @(posedge clk); #2;
    rd = 0; wr = 0; cpu_en = 0; ref_en = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    cyc(0, 1, a, d, 0, 0);
  endtask

  task automatic idle(input logic c, input logic f);
    cyc(0, 0, 8'h0, 32'h0, c, f);
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string req,
                           input logic c = 0, input logic f = 0);
    rd = 1; addr = a; cpu_en = c; ref_en = f;
    #1;
    check(req, rdata, exp);
    @(posedge clk); #2;
    rd = 0; cpu_en = 0; ref_en = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    cur_req = "R1";
    expect_rd(8'h0, 32'h0, "R1 ctrl");
    expect_rd(8'h4, 32'h0, "R1 reload");
    expect_rd(8'h8, 32'h0, "R1 count");
    idle(1, 1);
    expect_rd(8'h8, 32'h0, "R1 stopped");

    // R3 only bits 2:0 stored
    cur_req = "R3";
    wr_reg(8'h0, 32'hFFFF_FFF0);
    expect_rd(8'h0, 32'h0, "R3 upper ignored");
    wr_reg(8'h0, 32'h0000_0006);
    expect_rd(8'h0, 32'h6, "R3 bits");
    wr_reg(8'h0, 32'h0);

    // R4 reload width
    cur_req = "R4";
    wr_reg(8'h4, 32'hABCD_EF12);
    expect_rd(8'h4, 32'h00CD_EF12, "R4 reload");

    // R11 calibration
    cur_req = "R11";
    expect_rd(8'hC, 32'h0, "R11 cal");

    // R2 rejected accesses
    cur_req = "R2";
    priv = 0; wr_reg(8'h4, 32'h55); priv = 1;
    full = 0; wr_reg(8'h4, 32'h66); full = 0; expect_rd(8'h4, 32'h0, "R2 narrow read"); full = 1;
    wr_reg(8'h10, 32'h77);
    expect_rd(8'h10, 32'h0, "R2 bad offset");
    priv = 0; wr_reg(8'h0, 32'h7); wr_reg(8'h8, 32'h0); priv = 1;
    expect_rd(8'h4, 32'h00CD_EF12, "R2 reload kept");
    expect_rd(8'h0, 32'h0, "R2 ctrl kept");

    // R5/R6 processor-rate run with interrupts
    cur_req = "R6";
    wr_reg(8'h4, 32'h3);
    wr_reg(8'h0, 32'h7);
    for (int i = 0; i < 20; i++) cyc(1, 0, 8'h8, 0, 1, 0);
    expect_rd(8'h0, {15'h0, m_flag, 16'h7}, "R6 flag via model");
    expect_rd(8'h0, 32'h7, "R7 cleared after read");

    // R5 reference source, processor tick ignored
    cur_req = "R5";
    wr_reg(8'h0, 32'h0);
    wr_reg(8'h8, 32'h0);
    wr_reg(8'h0, 32'h3);
    for (int i = 0; i < 15; i++) cyc(1, 0, 8'h8, 0, 1, (i % 3) == 0);

    // R7 expiry in the same cycle as status read
    cur_req = "R7";
    wr_reg(8'h0, 32'h0);
    wr_reg(8'h4, 32'h2);
    wr_reg(8'h8, 32'h0);
    wr_reg(8'h0, 32'h3);
    idle(0, 1);
    idle(0, 1);
    expect_rd(8'h8, 32'h1, "R5 at one");
    expect_rd(8'h0, 32'h3, "R7 read at expiry", 0, 1);
    expect_rd(8'h0, 32'h0001_0003, "R7 flag survives");
    expect_rd(8'h0, 32'h3, "R7 cleared");

    // R8 counter write against expiry
    cur_req = "R8";
    idle(0, 1);
    idle(0, 1);
    expect_rd(8'h8, 32'h1, "R8 at one");
    cyc(0, 1, 8'h8, 32'hDEAD_BEEF, 0, 1);
    expect_rd(8'h8, 32'h0, "R8 zeroed");
    expect_rd(8'h0, 32'h3, "R8 no flag");
    idle(0, 1);
    expect_rd(8'h8, 32'h2, "R8 reload after clear");
    wr_reg(8'h4, 32'h0);
    wr_reg(8'h8, 32'h0);
    wr_reg(8'h4, 32'h5);
    idle(0, 1); idle(0, 1); idle(0, 1);
    expect_rd(8'h8, 32'h0, "R8 stopped");

    // R9 expiry with zero reload
    cur_req = "R9";
    wr_reg(8'h0, 32'h0);
    wr_reg(8'h0, 32'h3);
    idle(0, 1);
    expect_rd(8'h8, 32'h5, "R9 loaded");
    wr_reg(8'h4, 32'h0);
    for (int i = 0; i < 5; i++) idle(0, 1);
    expect_rd(8'h0, 32'h0001_0003, "R9 enable kept");
    idle(0, 1); idle(0, 1);
    expect_rd(8'h8, 32'h0, "R9 halted");

    // R10 enable and source changes
    cur_req = "R10";
    wr_reg(8'h4, 32'h4);
    wr_reg(8'h0, 32'h0);
    wr_reg(8'h0, 32'h3);
    idle(0, 1); idle(0, 1);
    expect_rd(8'h8, 32'h3, "R10 started");
    wr_reg(8'h0, 32'h2);
    idle(0, 1); idle(0, 1);
    expect_rd(8'h8, 32'h3, "R10 held");
    wr_reg(8'h0, 32'h3);
    idle(0, 1);
    expect_rd(8'h8, 32'h2, "R10 resumed");
    wr_reg(8'h0, 32'h7);
    idle(1, 0);
    expect_rd(8'h8, 32'h1, "R10 source swap");

    // R6 expiry without interrupt enable
    cur_req = "R6";
    wr_reg(8'h0, 32'h5);
    idle(1, 0);
    expect_rd(8'h0, 32'h0001_0005, "R6 flag no irq");

    // R1 reset mid-run
    cur_req = "R1";
    wr_reg(8'h0, 32'h7);
    rst_n = 0; @(posedge clk); #2 rst_n = 1;
    expect_rd(8'h0, 32'h0, "R1 ctrl after reset");
    expect_rd(8'h4, 32'h0, "R1 reload after reset");

    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule